// File: doc/BRIEF.md
# Single-Thread Data-Consistency Monitor

This block watches a FIFO's request and data pins and checks one property: a word written under a tag must come back unchanged, one cycle after the read request that carries the same tag. The property has two local values, the written data and the written tag. In a general monitor, every write that is still in flight would need its own copy of them. Here the automaton follows exactly one evaluation thread instead. The thread is chosen by two free inputs. A start selector picks the cycle where the thread begins, and a latch lets that happen only once. A repeat selector decides, on every cycle of the unbounded wait, whether the thread keeps waiting or moves on to test the read. As a result, each local value has exactly one holding register, whatever the wait length.

When a formal tool drives the two selectors freely, it explores every start cycle and every wait length, one thread at a time. In simulation, the selectors can be aimed at a chosen write and its read. The block reports its one-hot state vector and a fail flag. The fail flag stays high until reset.

Top module: `sva_mon`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes idle and `fail_o` is 0. The state bits of `state_o` are: bit 0 idle, bit 1 waiting (repetition), bit 2 tag check, bit 3 data check, bit 4 pass, bit 5 fail.
- R2: Exactly one bit of `state_o` is 1 in every cycle after reset.
- R3: In the idle state, the automaton stays idle on any edge where `start_sel` is 0.
- R4: The thread starts at most once. After the first edge that leaves idle, `start_sel` has no effect until reset.
- R5: On the start edge, with `wr_req` at 1, the state moves to waiting and the current `wr_data` and `wr_tag` are captured. With `wr_req` at 0, the state moves to pass. The captured values do not change on any other edge.
- R6: From waiting, `rep_sel` = 1 keeps the state in waiting and `rep_sel` = 0 moves it to tag check.
- R7: From tag check, the state moves to data check if `rd_req` is 1 and `rd_tag` equals the captured tag. Otherwise it moves to pass.
- R8: From data check, the state moves to pass if `rd_data` equals the captured data, and to fail otherwise.
- R9: The pass and fail states keep their value until reset.
- R10: `fail_o` is 1 exactly when the fail state is active and data check is not. It rises on the edge after a wrong `rd_data` was presented in data check, which is two edges after the matching read request, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | FIFO write request |
| wr_data | input | DATA_W | FIFO write data |
| wr_tag | input | TAG_W | Tag of the word being written |
| rd_req | input | 1 | FIFO read request |
| rd_tag | input | TAG_W | Tag of the word being read |
| rd_data | input | DATA_W | FIFO output data, valid one cycle after `rd_req` |
| start_sel | input | 1 | Free choice: begin the thread in this cycle |
| rep_sel | input | 1 | Free choice: 1 keeps waiting, 0 leaves the wait |
| fail_o | output | 1 | Sticky property violation |
| state_o | output | NUM_ST | One-hot automaton state |

## Verification
The bench builds the block with the default 8-bit data and 4-bit tags. Its behavioural FIFO model therefore exercises tag wrap-around, and a single-bit data corruption falls well inside the compared width. The selectors are generated in several ways: never starting, starting on a cycle without a write, random waiting, and aiming the wait exactly at the matching read or at a read with a different tag. This brings the vacuous pass, the real pass, the tag mismatch and the timed failure all within reach.

// File: rtl/sva_mon_pkg.sv
package sva_mon_pkg;

    localparam int NUM_ST = 6;

    typedef enum int unsigned {
        ST_IDLE = 0,
        ST_WAIT = 1,
        ST_TAG  = 2,
        ST_DAT  = 3,
        ST_PASS = 4,
        ST_FAIL = 5
    } st_idx_e;

    typedef logic [NUM_ST-1:0] st_vec_t;

    // Transition conditions seen by the one-hot network in one cycle.
    typedef struct packed {
        logic start;    // effective start (already gated by the once latch)
        logic wr;       // write request present
        logic rep;      // repeat selector
        logic tag_hit;  // read request with matching tag
        logic dat_ok;   // output data equals captured data
    } cond_t;

    function automatic st_vec_t st_bit(st_idx_e i);
        return st_vec_t'(1) << int'(i);
    endfunction

endpackage

// File: rtl/sva_mon_start.sv
module sva_mon_start (
    input  logic clk,
    input  logic rst,
    input  logic start_sel,
    output logic start_eff
);
    logic done_q;

    assign start_eff = start_sel & ~done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= done_q | start_eff;
    end

    // R4
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        start_eff |=> !start_eff);
endmodule

// File: rtl/sva_mon_hold.sv
module sva_mon_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sva_mon_fsm.sv
module sva_mon_fsm
    import sva_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cond_t   c,
    output st_vec_t st
);
    st_vec_t nx;

    // Each bit is the OR over its predecessors of (predecessor & edge condition).
    always_comb begin
        nx = '0;
        nx[ST_IDLE] = st[ST_IDLE] & ~c.start;
        nx[ST_WAIT] = (st[ST_IDLE] & c.start & c.wr)
                    | (st[ST_WAIT] & c.rep);
        nx[ST_TAG]  = st[ST_WAIT] & ~c.rep;
        nx[ST_DAT]  = st[ST_TAG] & c.tag_hit;
        nx[ST_PASS] = (st[ST_IDLE] & c.start & ~c.wr)
                    | (st[ST_TAG] & ~c.tag_hit)
                    | (st[ST_DAT] & c.dat_ok)
                    | st[ST_PASS];
        nx[ST_FAIL] = (st[ST_DAT] & ~c.dat_ok)
                    | st[ST_FAIL];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= st_bit(ST_IDLE);
        else     st <= nx;
    end

    // R2
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);

    // R3
    idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st[ST_IDLE] && !c.start) |=> st[ST_IDLE]);

    // R6
    loop_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (st[ST_WAIT] && c.rep) |=> st[ST_WAIT]);

    // R6
    loop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st[ST_WAIT] && !c.rep) |=> st[ST_TAG]);

    // R9
    pass_keep_chk: assert property (@(posedge clk) disable iff (rst)
        st[ST_PASS] |=> st[ST_PASS]);
endmodule

// File: rtl/sva_mon.sv
module sva_mon
    import sva_mon_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              rd_req,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              start_sel,
    input  logic              rep_sel,
    output logic              fail_o,
    output logic [NUM_ST-1:0] state_o
);
    logic              start_eff;
    logic              cap_en;
    logic [DATA_W-1:0] data_q;
    logic [TAG_W-1:0]  tag_q;
    cond_t             cnd;
    st_vec_t           st;

    sva_mon_start u_start (
        .clk       (clk),
        .rst       (rst),
        .start_sel (start_sel),
        .start_eff (start_eff)
    );

    // The only substitution edge: idle -> waiting.
    assign cap_en = st[ST_IDLE] & start_eff & wr_req;

    sva_mon_hold #(.W(DATA_W)) u_data (
        .clk  (clk),
        .rst  (rst),
        .load (cap_en),
        .d    (wr_data),
        .q    (data_q)
    );

    sva_mon_hold #(.W(TAG_W)) u_tag (
        .clk  (clk),
        .rst  (rst),
        .load (cap_en),
        .d    (wr_tag),
        .q    (tag_q)
    );

    always_comb begin
        cnd.start   = start_eff;
        cnd.wr      = wr_req;
        cnd.rep     = rep_sel;
        cnd.tag_hit = rd_req & (rd_tag == tag_q);
        cnd.dat_ok  = (rd_data == data_q);
    end

    sva_mon_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .c   (cnd),
        .st  (st)
    );

    assign state_o = st;
    assign fail_o  = st[ST_FAIL] & ~st[ST_DAT];

    // R5
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(state_o[ST_IDLE] && start_sel && wr_req) |=> ($stable(data_q) && $stable(tag_q)));

    // R7
    tag_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o[ST_TAG] && !rd_req) |=> state_o[ST_PASS]);

    // R8
    data_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o[ST_DAT] && rd_data != data_q) |=> fail_o);

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);
endmodule

// File: tb/sim_sva_mon.sv
module sim_sva_mon;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int TW = 4;
    localparam int L  = 48;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0, start_sel = 1'b0, rep_sel = 1'b0;
    logic [DW-1:0] wr_data = '0, rd_data = '0;
    logic [TW-1:0] wr_tag = '0, rd_tag = '0;
    logic          fail_o;
    logic [NS-1:0] state_o;

    sva_mon #(.DATA_W(DW), .TAG_W(TW)) u0 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .wr_tag(wr_tag),
        .rd_req(rd_req), .rd_tag(rd_tag), .rd_data(rd_data),
        .start_sel(start_sel), .rep_sel(rep_sel), .fail_o(fail_o), .state_o(state_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // Stimulus trace for one scenario
    bit            st_a[L], wr_a[L], rd_a[L], rp_a[L];
    logic [DW-1:0] wd_a[L];
    logic [DW-1:0] dout_a[L+1];
    logic [TW-1:0] wt_a[L], rt_a[L];
    int            exp_a[L];
    int            s_cyc;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic do_reset();
        rst = 1'b1;
        wr_req = 0; rd_req = 0; start_sel = 0; rep_sel = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: idle one-hot, no fail
        chk(state_o == 6'b000001, "R1 state", int'(state_o), 1);
        chk(fail_o == 1'b0, "R1 fail", int'(fail_o), 0);
    endtask

    // mode: 0 never start, 1 random wait, 2 aim at matching read,
    //       3 start without write, 4 aim at a read with other tag
    task automatic gen(int mode, int s, bit corrupt, bit hold_start, output bit aimed);
        logic [DW-1:0] qd[$];
        int            qi[$];
        int            in_cnt, out_cnt, item_s, r_hit, tgt;
        logic [DW-1:0] d;
        int            id;
        in_cnt = 0; out_cnt = 0; item_s = -1; r_hit = -1; tgt = -1;
        s_cyc = s;
        dout_a[0] = $urandom;
        for (int c = 0; c < L; c++) begin
            rd_a[c] = 0;
            rt_a[c] = TW'($urandom);
            dout_a[c+1] = dout_a[c];
            if (qd.size() > 0 && $urandom_range(2, 0) == 0) begin
                rd_a[c] = 1;
                rt_a[c] = TW'(out_cnt);
                d  = qd.pop_front();
                id = qi.pop_front();
                if (id == item_s) begin
                    r_hit = c;
                    if (corrupt) d = d ^ 8'h10;
                end
                dout_a[c+1] = d;
                out_cnt++;
            end
            if (c == s) wr_a[c] = (mode != 3);
            else        wr_a[c] = (qd.size() < 8) && ($urandom_range(1, 0) == 1);
            wd_a[c] = DW'($urandom);
            wt_a[c] = TW'(in_cnt);
            if (wr_a[c]) begin
                if (c == s) item_s = in_cnt;
                qd.push_back(wd_a[c]);
                qi.push_back(in_cnt);
                in_cnt++;
            end
            rp_a[c] = ($urandom_range(3, 0) != 0);
            if (mode == 0)      st_a[c] = 0;
            else if (c < s)     st_a[c] = 0;
            else if (c == s)    st_a[c] = 1;
            else                st_a[c] = hold_start ? 1'b1 : bit'($urandom_range(1, 0));
        end
        if (mode == 2) tgt = r_hit;
        if (mode == 4)
            for (int c = s + 2; c < L - 4; c++)
                if (tgt < 0 && rd_a[c] && rt_a[c] != wt_a[s]) tgt = c;
        aimed = 0;
        if (tgt >= s + 2 && tgt < L - 3) begin
            for (int c = s + 1; c < tgt - 1; c++) rp_a[c] = 1;
            rp_a[tgt-1] = 0;
            aimed = 1;
        end
    endtask

    // Behavioural expectation of the single thread over the trace.
    task automatic model();
        int            cur;
        logic [DW-1:0] cd;
        logic [TW-1:0] ct;
        cur = 0; cd = '0; ct = '0;
        for (int c = 0; c < L; c++) begin
            exp_a[c] = cur;
            if (cur == 0) begin
                if (st_a[c]) begin
                    if (wr_a[c]) begin cur = 1; cd = wd_a[c]; ct = wt_a[c]; end
                    else cur = 4;
                end
            end else if (cur == 1) cur = rp_a[c] ? 1 : 2;
            else if (cur == 2) cur = (rd_a[c] && rt_a[c] == ct) ? 3 : 4;
            else if (cur == 3) cur = (dout_a[c] == cd) ? 4 : 5;
        end
    endtask

    function automatic string req_of(int e, int c);
        case (e)
            0: return "R3";
            1: return (c == s_cyc + 1) ? "R5" : "R6";
            2: return "R7";
            3: return "R8";
            4: return (c == s_cyc + 1) ? "R5" : "R9";
            default: return "R9";
        endcase
    endfunction

    task automatic run(int mode, int s, bit corrupt, bit hold_start, output bit aimed);
        gen(mode, s, corrupt, hold_start, aimed);
        model();
        do_reset();
        for (int c = 0; c < L; c++) begin
            chk(state_o == (NS'(1) << exp_a[c]), req_of(exp_a[c], c),
                int'(state_o), 1 << exp_a[c]);
            chk($countones(state_o) == 1, "R2 onehot", $countones(state_o), 1);
            chk(fail_o == (exp_a[c] == 5), "R10 fail_o", int'(fail_o), int'(exp_a[c] == 5));
            wr_req = wr_a[c]; wr_data = wd_a[c]; wr_tag = wt_a[c];
            rd_req = rd_a[c]; rd_tag = rt_a[c]; rd_data = dout_a[c];
            start_sel = st_a[c]; rep_sel = rp_a[c];
            @(negedge clk);
        end
        // R4: start_sel activity after the start never returns the thread to idle
        if (mode != 0)
            chk(state_o[0] == 1'b0, "R4 no restart", int'(state_o), 1 << exp_a[L-1]);
    endtask

    initial begin
        bit aimed;
        int n_aim_ok, n_aim_bad, n_aim_mis;
        n_aim_ok = 0; n_aim_bad = 0; n_aim_mis = 0;
        // R3: never started
        run(0, 0, 0, 0, aimed);
        // R5: start without a write -> pass
        run(3, 5, 0, 1, aimed);
        // R6: random waiting, several starts
        for (int k = 0; k < 6; k++) run(1, 2 + k, 0, k[0], aimed);
        // R8 pass path: aimed at matching read with intact data
        for (int k = 0; k < 40 && n_aim_ok < 3; k++) begin
            run(2, 3 + (k % 6), 0, 1, aimed);
            if (aimed) n_aim_ok++;
        end
        // R10: aimed at matching read with corrupted data
        for (int k = 0; k < 40 && n_aim_bad < 3; k++) begin
            run(2, 4 + (k % 5), 1, k[0], aimed);
            if (aimed) n_aim_bad++;
        end
        // R7: aimed at a read carrying another tag
        for (int k = 0; k < 40 && n_aim_mis < 2; k++) begin
            run(4, 2 + (k % 5), 0, 1, aimed);
            if (aimed) n_aim_mis++;
        end
        chk(n_aim_ok == 3, "R8 aimed pass runs", n_aim_ok, 3);
        chk(n_aim_bad == 3, "R10 aimed fail runs", n_aim_bad, 3);
        chk(n_aim_mis == 2, "R7 aimed mismatch runs", n_aim_mis, 2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule